// File: doc/BRIEF.md
# Greedy Two-Process Cache Block Partitioner

This block splits a fixed number of cache blocks between two competing processes, A and B. Each process supplies a table of marginal gains. Entry c of a table is the number of misses saved when that process grows from c blocks to c+1 blocks. That is the drop in its miss count between the two sizes, scaled by how often the process references the cache. After a start pulse, the block hands out one cache block per clock. In each cycle it gives the block to the process whose next gain is larger.

The block reads the tables through two combinational lookup ports. Each port presents an index and expects the gain for that index in the same cycle. The index equals the number of blocks the process already holds. A process whose table is used up receives nothing more, and the remaining blocks go to the other process. When every block has been given out, a one-cycle done pulse marks the end of the run. The two final counts then stay on the outputs until the next start.

Top module: `greedy_partitioner`

## Requirements
- R1: After reset, busy and done are 0 and both block counts are 0.
- R2: A start pulse while idle clears both counts. Busy is then high for exactly CAPACITY cycles, starting the next cycle, and exactly one block is granted in each busy cycle.
- R3: In each busy cycle, a_idx and b_idx equal cnt_a and cnt_b. The block goes to the process whose gain at that index is larger, and grant_to_b = 1 means process B receives it.
- R4: When both processes still have table entries and their gains are equal, process A receives the block (grant_to_b = 0).
- R5: A process whose count has reached its table depth (DEPTH_A or DEPTH_B) receives no more blocks. Every remaining block goes to the other process.
- R6: A count never exceeds the table depth of its process. When done is high, cnt_a + cnt_b equals CAPACITY.
- R7: Done is high for exactly one cycle, the cycle right after the last grant, and busy is low in that cycle.
- R8: While idle and without a start pulse, both counts hold their values.
- R9: A start pulse that arrives while busy is ignored. The run continues and gives the same result as a run without that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an allocation when idle |
| a_idx | output | CNTW | Gain table index requested for process A |
| a_gain | input | GAIN_W | Gain of process A at a_idx |
| b_idx | output | CNTW | Gain table index requested for process B |
| b_gain | input | GAIN_W | Gain of process B at b_idx |
| busy | output | 1 | Allocation in progress; one grant per cycle |
| grant_to_b | output | 1 | Current grant goes to B (1) or A (0) while busy |
| done | output | 1 | One-cycle pulse after the final grant |
| cnt_a | output | CNTW | Blocks held by process A |
| cnt_b | output | CNTW | Blocks held by process B |

## Verification
The bench builds the block with CAPACITY = 8, DEPTH_A = 4, DEPTH_B = 6 and 16-bit gains. With these sizes, either table can run out before the cache is full: A runs out once it holds four blocks, and B runs out when it wins six. That puts the hand-over of the remaining blocks to the other process within reach in a short run. The eight-block capacity also lets the bench drive the four-block alternating example, a run of equal gains, and a start pulse in the middle of a run, each within a few dozen cycles.

// File: rtl/gpart_pkg.sv
package gpart_pkg;
   typedef enum logic [0:0] {
      GP_IDLE = 1'b0,
      GP_RUN  = 1'b1
   } gp_state_e;

   localparam int GP_NPROC = 2;

   function automatic int gp_cnt_bits(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/gpart_tally.sv
module gpart_tally #(
   parameter int CNTW  = 7,
   parameter int LIMIT = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            bump,
   output logic [CNTW-1:0] cnt,
   output logic            room
);
   localparam logic [CNTW-1:0] LIM = CNTW'(LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (bump)  cnt <= cnt + 1'b1;
   end

   assign room = (cnt < LIM);

   // R5: a process with an exhausted table is never granted
   p_no_grant_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bump |-> room);
   // R6: count never passes the depth
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM);
endmodule

// File: rtl/gpart_chooser.sv
module gpart_chooser #(
   parameter int GAIN_W = 16
) (
   input  logic [GAIN_W-1:0] a_gain,
   input  logic [GAIN_W-1:0] b_gain,
   input  logic              a_room,
   input  logic              b_room,
   output logic              pick_b
);
   // ties favour A; an exhausted side never wins
   always_comb begin
      if (!b_room)      pick_b = 1'b0;
      else if (!a_room) pick_b = 1'b1;
      else              pick_b = (b_gain > a_gain);
   end
endmodule

// File: rtl/gpart_seq.sv
module gpart_seq
   import gpart_pkg::*;
#(
   parameter int CAPACITY = 64,
   parameter int CNTW     = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic clear,
   output logic done
);
   localparam logic [CNTW-1:0] LAST = CNTW'(CAPACITY - 1);

   gp_state_e       state;
   logic [CNTW-1:0] step;

   assign busy  = (state == GP_RUN);
   assign clear = (state == GP_IDLE) && start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= GP_IDLE;
         step  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            GP_IDLE: begin
               if (start) begin
                  state <= GP_RUN;
                  step  <= '0;
               end
            end
            GP_RUN: begin
               step <= step + 1'b1;
               if (step == LAST) begin
                  state <= GP_IDLE;
                  done  <= 1'b1;
               end
            end
            default: state <= GP_IDLE;
         endcase
      end
   end

   // R7: done is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: a start pulse never cuts a run short
   p_run_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (step != LAST) |=> busy);
   // R2: a run ends on the last step
   p_run_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (step == LAST) |=> !busy && done);
endmodule

// File: rtl/greedy_partitioner.sv
module greedy_partitioner
   import gpart_pkg::*;
#(
   parameter int   GAIN_W   = 16,
   parameter int   CAPACITY = 64,
   parameter int   DEPTH_A  = 64,
   parameter int   DEPTH_B  = 64,
   localparam int  CNTW     = gp_cnt_bits(CAPACITY)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [CNTW-1:0]   a_idx,
   input  logic [GAIN_W-1:0] a_gain,
   output logic [CNTW-1:0]   b_idx,
   input  logic [GAIN_W-1:0] b_gain,
   output logic              busy,
   output logic              grant_to_b,
   output logic              done,
   output logic [CNTW-1:0]   cnt_a,
   output logic [CNTW-1:0]   cnt_b
);
   if (CAPACITY < 1)                        $error("CAPACITY must be at least 1");
   if (GAIN_W < 1)                          $error("GAIN_W must be at least 1");
   if (DEPTH_A < 1 || DEPTH_A > CAPACITY)   $error("DEPTH_A out of range");
   if (DEPTH_B < 1 || DEPTH_B > CAPACITY)   $error("DEPTH_B out of range");
   if (DEPTH_A + DEPTH_B < CAPACITY)        $error("tables cannot fill the cache");

   logic            clear;
   logic            pick_b;
   logic [GP_NPROC-1:0] bump;
   logic [GP_NPROC-1:0] room;
   logic [CNTW-1:0] cnt [GP_NPROC];

   gpart_seq #(.CAPACITY(CAPACITY), .CNTW(CNTW)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .clear (clear),
      .done  (done)
   );

   gpart_chooser #(.GAIN_W(GAIN_W)) u_pick (
      .a_gain (a_gain),
      .b_gain (b_gain),
      .a_room (room[0]),
      .b_room (room[1]),
      .pick_b (pick_b)
   );

   assign bump[0] = busy && !pick_b;
   assign bump[1] = busy &&  pick_b;

   for (genvar gi = 0; gi < GP_NPROC; gi++) begin : g_proc
      gpart_tally #(
         .CNTW  (CNTW),
         .LIMIT ((gi == 0) ? DEPTH_A : DEPTH_B)
      ) u_tally (
         .clk   (clk),
         .rst_n (rst_n),
         .clear (clear),
         .bump  (bump[gi]),
         .cnt   (cnt[gi]),
         .room  (room[gi])
      );
   end

   assign cnt_a      = cnt[0];
   assign cnt_b      = cnt[1];
   assign a_idx      = cnt[0];
   assign b_idx      = cnt[1];
   assign grant_to_b = busy && pick_b;

   logic [CNTW:0] total;
   assign total = {1'b0, cnt_a} + {1'b0, cnt_b};

   // R2: every busy cycle adds exactly one block
   p_one_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> total == $past(total) + 1'b1);
   // R6: the whole capacity is handed out at done
   p_full_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> total == (CNTW+1)'(CAPACITY));
   // R8: counts hold while idle without start
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(cnt_a) && $stable(cnt_b));
   // R5: exhausted A hands the block to B
   p_spill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !room[0] |-> grant_to_b);
endmodule

// File: tb/greedy_partitioner_tb.sv
module greedy_partitioner_tb;
   localparam int CLK_PERIOD = 10;
   localparam int GW  = 16;
   localparam int CAP = 8;
   localparam int DA  = 4;
   localparam int DB  = 6;
   localparam int CW  = $clog2(CAP + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] a_idx, b_idx, cnt_a, cnt_b;
   logic [GW-1:0] a_gain, b_gain;
   logic          busy, grant_to_b, done;

   int ga [8];
   int gb [8];

   int checks = 0;
   int errors = 0;

   int ma, mb, mstep;
   bit mbusy, mdone;
   int gq [$];
   int busy_cycles;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign a_gain = (int'(a_idx) < DA) ? GW'(ga[a_idx]) : '0;
   assign b_gain = (int'(b_idx) < DB) ? GW'(gb[b_idx]) : '0;

   greedy_partitioner #(.GAIN_W(GW), .CAPACITY(CAP), .DEPTH_A(DA), .DEPTH_B(DB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .a_idx(a_idx), .a_gain(a_gain), .b_idx(b_idx), .b_gain(b_gain),
      .busy(busy), .grant_to_b(grant_to_b), .done(done),
      .cnt_a(cnt_a), .cnt_b(cnt_b)
   );

   function automatic bit model_pick_b();
      bit aok = (ma < DA);
      bit bok = (mb < DB);
      if (!bok) return 1'b0;
      if (!aok) return 1'b1;
      return gb[mb] > ga[ma];
   endfunction

   // behavioural reference, advanced on each edge
   always @(posedge clk) begin
      if (!rst_n) begin
         ma = 0; mb = 0; mstep = 0; mbusy = 0; mdone = 0;
      end else if (mbusy) begin
         if (model_pick_b()) begin mb++; gq.push_back(1); end
         else begin ma++; gq.push_back(0); end
         busy_cycles++;
         mstep++;
         mdone = 0;
         if (mstep == CAP) begin mbusy = 0; mdone = 1; end
      end else begin
         mdone = 0;
         if (start) begin ma = 0; mb = 0; mstep = 0; mbusy = 1; end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == mbusy, "R2 busy", busy, mbusy);
         chk(done == mdone, "R7 done", done, mdone);
         chk(int'(cnt_a) == ma, "R3 cnt_a", cnt_a, ma);
         chk(int'(cnt_b) == mb, "R3 cnt_b", cnt_b, mb);
         if (mbusy) begin
            chk(int'(a_idx) == ma, "R3 a_idx", a_idx, ma);
            chk(int'(b_idx) == mb, "R3 b_idx", b_idx, mb);
            chk(grant_to_b == model_pick_b(), "R3 grant", grant_to_b, model_pick_b());
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic load(input int a0, a1, a2, a3, input int b0, b1, b2, b3, b4, b5);
      ga = '{a0, a1, a2, a3, 0, 0, 0, 0};
      gb = '{b0, b1, b2, b3, b4, b5, 0, 0};
   endtask

   initial begin
      fork
         begin
            busy_cycles = 0;
            repeat (3) @(negedge clk);
            // R1 reset state
            chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
            chk(cnt_a == 0 && cnt_b == 0, "R1 counts", cnt_a + cnt_b, 0);
            rst_n = 1'b1;
            @(negedge clk);

            // R3 alternating example
            load(2111, 987, 409, 100, 1568, 746, 282, 250, 90, 5);
            gq.delete(); busy_cycles = 0;
            pulse_start(); wait_done();
            chk(gq.size() == CAP, "R2 grants", gq.size(), CAP);
            chk(busy_cycles == CAP, "R2 busy cycles", busy_cycles, CAP);
            chk(gq[0] == 0 && gq[1] == 1 && gq[2] == 0 && gq[3] == 1, "R3 ABAB",
                gq[0]*8 + gq[1]*4 + gq[2]*2 + gq[3], 5);
            chk(cnt_a == 4 && cnt_b == 4, "R6 final", cnt_a*16 + cnt_b, 68);

            // R8 hold while idle
            repeat (5) @(negedge clk);
            chk(cnt_a == 4 && cnt_b == 4, "R8 hold", cnt_a*16 + cnt_b, 68);

            // R4 ties then R5 exhaustion of A
            load(500, 500, 500, 500, 500, 500, 500, 500, 500, 500);
            gq.delete();
            pulse_start(); wait_done();
            chk(gq[0] == 0 && gq[1] == 0 && gq[2] == 0 && gq[3] == 0, "R4 tie to A",
                gq[0] + gq[1] + gq[2] + gq[3], 0);
            chk(gq[4] == 1 && gq[7] == 1, "R5 spill to B", gq[4] + gq[7], 2);
            chk(cnt_a == DA && cnt_b == CAP - DA, "R5 counts", cnt_a, DA);

            // R5 exhaustion of B
            load(10, 9, 8, 7, 900, 800, 700, 600, 500, 400);
            gq.delete();
            pulse_start(); wait_done();
            chk(cnt_b == DB && cnt_a == CAP - DB, "R5 B exhausted", cnt_b, DB);
            chk(gq[6] == 0 && gq[7] == 0, "R5 spill to A", gq[6] + gq[7], 0);

            // R9 start while busy ignored
            load(2111, 987, 409, 100, 1568, 746, 282, 250, 90, 5);
            gq.delete(); busy_cycles = 0;
            pulse_start();
            @(negedge clk); @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
            wait_done();
            chk(busy_cycles == CAP, "R9 run length", busy_cycles, CAP);
            chk(cnt_a == 4 && cnt_b == 4, "R9 result", cnt_a*16 + cnt_b, 68);
            chk(!busy, "R9 idle after", busy, 0);
         end
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule